// File: doc/BRIEF.md
# Programmable Burst Column Address Generator

This block produces the column address stream for one read or write burst on a synchronous DRAM page. A one-cycle start pulse supplies the starting column together with a mode value. The mode value chooses the burst length (1, 2, 4, 8 or a whole page) and the ordering (sequential wrap or XOR interleave). From the next clock on, the block presents one column per cycle with a valid flag. A last-beat flag marks the final column of a fixed-length burst.

A whole-page burst walks forward through the page, wraps at the top and runs until a stop pulse ends it. A stop pulse also cuts short a fixed-length burst at any beat. A new start may arrive on any cycle, including one in the middle of a burst, and it begins a fresh burst at once. The block does not produce row or bank addresses, does not issue commands and holds no data.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first start pulse, `valid_o` and `last_o` are both 0.
- R2: When `start_i` is 1 at a clock edge, `valid_o` is 1 in the following cycle and `col_o` equals the `start_col_i` sampled at that edge. `len_i` and `ilv_i` are sampled at that same edge and hold for the whole burst.
- R3: The `len_i` encoding is 0 for 1 beat, 1 for 2 beats, 2 for 4 beats and 3 for 8 beats. A code from 4 to 7 selects a whole-page burst. A fixed burst with no stop and no restart is valid for exactly that many consecutive cycles, after which `valid_o` is 0.
- R4: With `ilv_i` = 0 and a fixed length BL = 2^k, beat i has the same upper bits (k and above) as the start column. Its low k bits are (start low bits + i) mod BL.
- R5: With `ilv_i` = 1 and a fixed length BL, beat i is the start column XOR i. Only the low log2(BL) bits change.
- R6: In a whole-page burst, beat i is (start + i) mod 512, so column 511 is followed by 0. `ilv_i` has no effect on it, and the burst runs for as long as no stop or start arrives.
- R7: `last_o` is 1 only on the final beat of a fixed burst. A 1-beat burst shows its single column with `last_o` = 1. `last_o` is never 1 during a whole-page burst.
- R8: When `stop_i` is 1 at an edge where `start_i` is 0, `valid_o` is 0 from the next cycle on. A stop pulse while no burst is running leaves `valid_o` at 0.
- R9: A start pulse during a running burst abandons that burst: the next cycle shows beat 0 of the new burst. When start and stop are 1 at the same edge, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a burst at this edge |
| start_col_i | input | 9 | First column of the burst |
| len_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleave ordering, 0 = sequential |
| stop_i | input | 1 | Ends the running burst |
| col_o | output | 9 | Current column, meaningful when valid_o is 1 |
| valid_o | output | 1 | A column is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Every one of the 512 start columns is run through each fixed length in both orderings, and every beat is compared against the arithmetic expectation. Starting columns that are not aligned to the burst length are what separate sequential wrap, which rotates the low bits, from interleave, which XORs them. These runs also expose any carry that leaks into the upper bits. Whole-page runs that start just below column 511, with interleave both off and on, show the wrap to 0, the absence of `last_o`, and that the ordering selection is ignored. Stops on several beats, idle stops, mid-burst restarts and a start coinciding with a stop show the ending and priority rules.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int MAX_FIXED_CODE = 3;

  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             ilv_q, page_q, valid_q;

  function automatic logic [COL_W-1:0] len_mask(input logic [LEN_W-1:0] code);
    logic [COL_W-1:0] m;
    m = '1;
    if (int'(code) <= MAX_FIXED_CODE) m = COL_W'((1 << code) - 1);
    return m;
  endfunction

  wire              is_page  = int'(len_i) > MAX_FIXED_CODE;
  wire              at_end   = ~page_q & (beat_q == mask_q);
  wire [COL_W-1:0]  seq_col  = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
  wire [COL_W-1:0]  ilv_col  = base_q ^ beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      base_q  <= start_col_i;
      beat_q  <= '0;
      mask_q  <= len_mask(len_i);
      ilv_q   <= ilv_i & ~is_page;
      page_q  <= is_page;
    end else if (stop_i) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      if (at_end) valid_q <= 1'b0;
      else        beat_q  <= beat_q + 1'b1;
    end
  end

  assign col_o   = ilv_q ? ilv_col : seq_col;
  assign valid_o = valid_q;
  assign last_o  = valid_q & at_end;
endmodule

module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  assert_start_beat0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));
  assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);
  assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !valid_o);
  assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o);
  assert_run_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !stop_i) |=> valid_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
  .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o));

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, ilv_i = 1'b0, stop_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_i = '0;
  logic [8:0] col_o;
  logic valid_o, last_o;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_gen u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_i(len_i), .ilv_i(ilv_i), .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int code, bit ilv, int i);
    int m;
    if (code > 3) return (s + i) % 512;
    m = (1 << code) - 1;
    if (ilv) return s ^ i;
    return (s & ~m) | ((s + i) & m);
  endfunction

  task automatic launch(int s, int code, bit ilv);
    start_i = 1'b1; start_col_i = 9'(s); len_i = 3'(code); ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0; start_col_i = '0; len_i = '0; ilv_i = 1'b0;
  endtask

  task automatic beat(string req, int s, int code, bit ilv, int i, bit exp_last);
    chk({req, " valid"}, int'(valid_o), 1);
    chk({req, " col"}, int'(col_o), exp_col(s, code, ilv, i));
    chk("R7 last", int'(last_o), int'(exp_last));
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 last", int'(last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(valid_o), 0);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    chk("R8 idle stop", int'(valid_o), 0);

    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int s = 0; s < 512; s++) begin
          launch(s, code, 1'(ilv));
          if (s == 0) chk("R2 beat0", int'(col_o), 0);
          for (int i = 0; i < (1 << code); i++) begin
            beat(ilv ? "R5" : "R4", s, code, 1'(ilv), i, i == (1 << code) - 1);
            @(negedge clk);
          end
          if (s % 64 == 3) chk("R3 ends", int'(valid_o), 0);
        end

    for (int ilv = 0; ilv < 2; ilv++) begin
      launch(505, 7 - ilv, 1'(ilv));
      for (int i = 0; i < 20; i++) begin
        beat("R6", 505, 7, 1'b0, i, 1'b0);
        if (i == 19) stop_i = 1'b1;
        @(negedge clk);
      end
      stop_i = 1'b0;
      chk("R8 page stop", int'(valid_o), 0);
    end

    for (int n = 0; n < 4; n++) begin
      launch(9'h0a5, 3, 1'b0);
      for (int i = 0; i <= n; i++) begin
        if (i == n) stop_i = 1'b1;
        @(negedge clk);
      end
      stop_i = 1'b0;
      chk("R8 early stop", int'(valid_o), 0);
    end

    launch(100, 3, 1'b1);
    @(negedge clk);
    launch(300, 2, 1'b0);
    beat("R9 restart", 300, 2, 1'b0, 0, 1'b0);
    @(negedge clk);
    beat("R9 restart", 300, 2, 1'b0, 1, 1'b0);
    stop_i = 1'b1;
    launch(77, 0, 1'b0);
    stop_i = 1'b0;
    beat("R9 start over stop", 77, 0, 1'b0, 0, 1'b1);
    @(negedge clk);
    chk("R3 single ends", int'(valid_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule